// File: doc/BRIEF.md
# Shared-Adder Add/Subtract Unit with Carry and Overflow Flags

This block adds or subtracts two equal-width operands through a single carry chain. A mode input chooses the operation. Subtraction reuses the adder: every bit of the second operand is inverted and the chain's carry-in is forced high, so the chain computes the first operand plus the two's complement of the second.

Two status flags are produced together on every evaluation. One reports an unsigned result that does not fit: a carry out on addition, or a borrow on subtraction. The other reports two's-complement overflow. The caller decides which interpretation applies and reads the matching flag. The unit is purely combinational: it has no clock, no state and no registered outputs.

Top module: `addsub_flags`

## Requirements
- R1: With `sub_mode` = 0, `result` equals (op_a + op_b) mod 2^WIDTH.
- R2: With `sub_mode` = 1, `result` equals (op_a - op_b) mod 2^WIDTH.
- R3: With `sub_mode` = 0, `carry_borrow` is 1 exactly when the unsigned sum op_a + op_b is at least 2^WIDTH.
- R4: With `sub_mode` = 1, `carry_borrow` is 1 exactly when op_a < op_b as unsigned values. This equals the inverted carry-out of the chain.
- R5: `sgn_ovf` is 1 exactly when the exact two's-complement result of the selected operation lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. This is the case when the carry into the top bit differs from the carry out of it.
- R6: On addition, two non-negative operands whose sum has its top bit set raise `sgn_ovf`. An example is the most-positive value plus 1.
- R7: On addition, two negative operands whose sum has its top bit clear raise `sgn_ovf`.
- R8: On subtraction, the most-negative value minus 1 raises `sgn_ovf`, and so does the most-positive value minus -1.
- R9: Subtracting equal operands gives `result` = 0, `carry_borrow` = 0 and `sgn_ovf` = 0.
- R10: Subtracting 0 from any value gives `result` = op_a and `carry_borrow` = 0.
- R11: The outputs follow any input change without a clock edge. The unit holds no state.
- R12: WIDTH is a parameter (default 12) and must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand (minuend on subtraction) |
| op_b | input | WIDTH | Second operand (subtrahend on subtraction) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH | Low WIDTH bits of the chain output |
| carry_borrow | output | 1 | Unsigned carry on add, borrow on subtract |
| sgn_ovf | output | 1 | Two's-complement overflow |

## Verification
The embedded assertions run whenever any input changes. They take for granted that every input bit is a known 0 or 1, because an unknown mode bit would leave the carry-in and the inversion undefined, so none of the checks would mean anything. The bench always drives fully defined values: a fixed vector table, directed edge operands (zero, all-ones, most-negative, most-positive) and values from `$urandom` truncated to the operand width. It also applies some inputs while the clock is held off and checks that the outputs still settle.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_borrow,
  output logic             sgn_ovf
);

  localparam int TOP = WIDTH - 1;

  // R12: a sign bit and at least one magnitude bit are needed
  if (WIDTH < 2) begin : g_width_check
    $error("addsub_flags: WIDTH must be at least 2");
  end

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   chain;

  assign b_eff    = op_b ^ {WIDTH{sub_mode}};
  assign chain[0] = sub_mode;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic prop;
    assign prop        = op_a[i] ^ b_eff[i];
    assign result[i]   = prop ^ chain[i];
    assign chain[i+1]  = (op_a[i] & b_eff[i]) | (prop & chain[i]);
  end

  assign carry_borrow = chain[WIDTH] ^ sub_mode;
  assign sgn_ovf      = chain[WIDTH] ^ chain[TOP];

  // Reference built from the language's own arithmetic, kept apart from the chain
  logic [WIDTH:0] chk_full;
  logic           chk_a_neg, chk_b_neg;
  assign chk_full  = sub_mode ? ({1'b0, op_a} - {1'b0, op_b})
                              : ({1'b0, op_a} + {1'b0, op_b});
  assign chk_a_neg = op_a[TOP];
  assign chk_b_neg = op_b[TOP] ^ sub_mode;

  always_comb begin
    if (!sub_mode) begin
      assert_sum_bits_R1: assert (result == chk_full[TOP:0]);
      assert_carry_out_R3: assert (carry_borrow == chk_full[WIDTH]);
      if (!chk_a_neg && !chk_b_neg)
        assert_pos_overflow_R6: assert (sgn_ovf == result[TOP]);
      if (chk_a_neg && chk_b_neg)
        assert_neg_overflow_R7: assert (sgn_ovf == !result[TOP]);
    end else begin
      assert_diff_bits_R2: assert (result == chk_full[TOP:0]);
      assert_borrow_R4: assert (carry_borrow == (op_a < op_b));
      if (op_a == op_b)
        assert_equal_sub_R9: assert (result == '0 && !carry_borrow && !sgn_ovf);
      if (op_b == '0)
        assert_sub_zero_R10: assert (result == op_a && !carry_borrow);
    end
    if (chk_a_neg != chk_b_neg)
      assert_no_overflow_R5: assert (!sgn_ovf);
    else
      assert_sign_flip_R5: assert (sgn_ovf == (result[TOP] != chk_a_neg));
  end

endmodule

// File: tb/tb_addsub_flags.sv
module tb_addsub_flags;

  localparam int W    = 12;
  localparam int SPAN = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] op_a, op_b, result;
  logic         sub_mode, carry_borrow, sgn_ovf;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  addsub_flags #(.WIDTH(W)) dut (
    .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode),
    .result(result), .carry_borrow(carry_borrow), .sgn_ovf(sgn_ovf)
  );

  // {mode, a, b}
  localparam logic [2*W:0] VEC [16] = '{
    {1'b0, 12'h000, 12'h000}, {1'b0, 12'hFFF, 12'h001},
    {1'b0, 12'h7FF, 12'h001}, {1'b0, 12'h800, 12'h800},
    {1'b0, 12'h800, 12'hFFF}, {1'b0, 12'h123, 12'h456},
    {1'b0, 12'hA5A, 12'h5A5}, {1'b0, 12'h400, 12'h400},
    {1'b1, 12'h000, 12'h001}, {1'b1, 12'h800, 12'h001},
    {1'b1, 12'h7FF, 12'hFFF}, {1'b1, 12'h555, 12'h555},
    {1'b1, 12'h9AB, 12'h000}, {1'b1, 12'h100, 12'h0FF},
    {1'b1, 12'h0FF, 12'h100}, {1'b1, 12'h000, 12'h800}
  };

  function automatic int sval(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - SPAN : int'(v);
  endfunction

  task automatic apply(input logic m, input logic [W-1:0] a, input logic [W-1:0] b,
                       input string req);
    int ua, ub, full, exact;
    logic [W-1:0] e_res;
    logic e_cb, e_ov;
    sub_mode = m; op_a = a; op_b = b;
    #1;
    ua = int'(a); ub = int'(b);
    if (!m) begin
      full  = ua + ub;
      e_cb  = full >= SPAN;
      exact = sval(a) + sval(b);
    end else begin
      full  = ua - ub + SPAN;
      e_cb  = ua < ub;
      exact = sval(a) - sval(b);
    end
    e_res = W'(full % SPAN);
    e_ov  = (exact > HALF - 1) || (exact < -HALF);
    applied++;
    if (result !== e_res || carry_borrow !== e_cb || sgn_ovf !== e_ov) begin
      miscompares++;
      $display("FAIL %s: mode=%0b a=%h b=%h got res=%h cb=%b ov=%b expected res=%h cb=%b ov=%b",
               req, m, a, b, result, carry_borrow, sgn_ovf, e_res, e_cb, e_ov);
    end
  endtask

  initial begin
    sub_mode = 1'b0; op_a = '0; op_b = '0;
    // R11: settled state with zero inputs, before any clock edge
    apply(1'b0, '0, '0, "R11");

    for (int i = 0; i < 16; i++)
      apply(VEC[i][2*W], VEC[i][2*W-1:W], VEC[i][W-1:0],
            VEC[i][2*W] ? "R2/R4/R5" : "R1/R3/R5");

    apply(1'b0, 12'h7FF, 12'h001, "R6");
    apply(1'b0, 12'h600, 12'h300, "R6");
    apply(1'b0, 12'h800, 12'hFFF, "R7");
    apply(1'b0, 12'h900, 12'hA00, "R7");
    apply(1'b1, 12'h800, 12'h001, "R8");
    apply(1'b1, 12'h7FF, 12'hFFF, "R8");
    apply(1'b0, 12'hFFF, 12'hFFF, "R3");
    apply(1'b1, 12'h3FE, 12'h3FF, "R4");
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] v = W'($urandom);
      apply(1'b1, v, v, "R9");
      apply(1'b1, v, '0, "R10");
    end
    apply(1'b1, 12'hFFF, 12'hFFF, "R9");
    apply(1'b1, 12'h800, 12'h000, "R10");

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      apply(1'($urandom), W'($urandom), W'($urandom), "R5/R12");
    end

    // R11: several changes inside one clock phase, no edge between them
    @(posedge clk); #1;
    apply(1'b0, 12'h00F, 12'h001, "R11");
    apply(1'b1, 12'h00F, 12'h001, "R11");
    apply(1'b0, 12'h7FF, 12'h7FF, "R11");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

endmodule